// File: doc/BRIEF.md
# CPU Special I/O Register Window

This block sits on the byte-wide I/O port path of a small 8-bit CPU core. The core issues IN/OUT-style accesses by 6-bit port number. The eight ports at the top of the space (0x38 to 0x3F) are served locally from core-owned registers:

- four extended address page registers
- the extended indirect jump register
- the two halves of the stack pointer
- the status byte

Every other port is forwarded in the same cycle to an external peripheral byte bus, at a fixed base offset.

The page registers and the extended indirect register each hold their byte pre-positioned in bits 23:16 of a 24-bit field. The address generators in the core can therefore use them directly as the upper part of a 24-bit address. Elaboration parameters say which optional registers exist. A write to an absent page register, or to the stack pointer high byte on a one-byte stack pointer build, is dropped without any effect. Reads have a uniform latency of one cycle, whether served locally or by the external bus.

Top module: `cpu_io_window`

## Requirements
- R1: While rst_ni is low and after its release, all page fields, the extended indirect field, the stack pointer and the status byte read as zero, and rd_valid_o and ext_req_o are 0.
- R2: The port decode is as follows, with reads returning the byte on rd_data_o one cycle after the request (rd_valid_o high in that cycle):
  - 0x38 selects page D.
  - 0x39 selects page X.
  - 0x3A selects page Y.
  - 0x3B selects page Z.
  - 0x3C selects the extended indirect register.
  - 0x3D selects the stack pointer low byte.
  - 0x3E selects the stack pointer high byte.
  - 0x3F selects the status byte.
  - A page or extended indirect read returns bits 23:16 of its field.
- R3: A page register write takes effect only when its bit of PAGE_EN is set (bit 0 D, bit 1 X, bit 2 Y, bit 3 Z). A write to a page register whose bit is clear leaves that field unchanged. The write data lands in bits 23:16, and bits 15:0 stay zero.
- R4: A write to the extended indirect register is always accepted and lands in bits 23:16 of its field.
- R5: A write to the stack pointer low byte replaces bits 7:0 and keeps bits 15:8.
- R6: A write to the stack pointer high byte replaces bits 15:8 and keeps bits 7:0 when SP_WIDE is 1. When SP_WIDE is 0, the write leaves the stack pointer unchanged.
- R7: The status byte is plain storage. A write stores the byte, and status_o and reads return it.
- R8: An access to a port below 0x38 raises ext_req_o in the same cycle, with:
  - ext_we_o equal to the access direction;
  - ext_addr_o equal to IO_BASE plus the port;
  - ext_wdata_o equal to the write data.
- R9: An access to 0x38 to 0x3F never raises ext_req_o. An external read completes the cycle after its request, with rd_valid_o high and rd_data_o equal to ext_rdata_i in that cycle.
- R10: A read of a window register issued in the cycle after a write to it returns the newly written value. Reads change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| acc_valid_i | input | 1 | Access request from the core |
| acc_write_i | input | 1 | 1 = OUT (write), 0 = IN (read) |
| acc_port_i | input | 6 | I/O port number |
| acc_wdata_i | input | 8 | Write data |
| rd_valid_o | output | 1 | Read data valid, one cycle after a read request |
| rd_data_o | output | 8 | Read data |
| ext_req_o | output | 1 | External bus request |
| ext_we_o | output | 1 | External bus write enable |
| ext_addr_o | output | ADDR_W | External bus address (IO_BASE + port) |
| ext_wdata_o | output | 8 | External bus write data |
| ext_rvalid_i | input | 1 | External read data valid |
| ext_rdata_i | input | 8 | External read data |
| page_d_o | output | 24 | Page D field |
| page_x_o | output | 24 | Page X field |
| page_y_o | output | 24 | Page Y field |
| page_z_o | output | 24 | Page Z field |
| ext_ind_o | output | 24 | Extended indirect field |
| sp_o | output | 16 | Stack pointer |
| status_o | output | 8 | Status byte |

## Verification
Two functions can fall in the same cycle. One is the completion of an external read, which drives rd_data_o from ext_rdata_i. The other is a new access, either a window write or a new external request. The bench issues external reads back to back with window writes and window reads, and issues window reads straight after writes to the same port. A behavioural reference model tracks every register, the one-cycle read pipeline and the external responses, and every output is compared each cycle. A second instance built with a one-byte stack pointer receives the same stimulus, so that dropped high-byte writes are judged at its sp_o.

// File: rtl/cpu_io_pkg.sv
package cpu_io_pkg;
  localparam int unsigned PORT_W    = 6;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned FIELD_W   = 24;
  localparam int unsigned FIELD_LSB = 16;
  localparam int unsigned SP_W      = 16;
  localparam int unsigned NUM_FIELD = 5;

  typedef enum logic [2:0] {
    WIN_PAGE_D  = 3'd0,
    WIN_PAGE_X  = 3'd1,
    WIN_PAGE_Y  = 3'd2,
    WIN_PAGE_Z  = 3'd3,
    WIN_EXT_IND = 3'd4,
    WIN_SP_LO   = 3'd5,
    WIN_SP_HI   = 3'd6,
    WIN_STATUS  = 3'd7
  } win_sel_e;
endpackage

// File: rtl/io_port_decode.sv
module io_port_decode
  import cpu_io_pkg::*;
(
  input  logic              valid_i,
  input  logic [PORT_W-1:0] port_i,
  output logic              win_hit_o,
  output logic              ext_hit_o,
  output win_sel_e          win_sel_o
);
  logic in_win;
  assign in_win    = (port_i[PORT_W-1:3] == '1);
  assign win_hit_o = valid_i && in_win;
  assign ext_hit_o = valid_i && !in_win;
  assign win_sel_o = win_sel_e'(port_i[2:0]);
endmodule

// File: rtl/io_byte_field.sv
module io_byte_field
  import cpu_io_pkg::*;
#(
  parameter bit ENABLE = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [FIELD_W-1:0] q_o,
  output logic [DATA_W-1:0]  byte_o
);
  logic [FIELD_W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                q <= '0;
    else if (ENABLE && we_i)    q <= FIELD_W'(wdata_i) << FIELD_LSB;
  end

  assign q_o    = q;
  assign byte_o = q[FIELD_LSB +: DATA_W];

  a_r3_absent_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !ENABLE) |=> $stable(q_o));
  a_r4_low_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (q_o[FIELD_LSB-1:0] == '0));
endmodule

// File: rtl/io_stack_ptr.sv
module io_stack_ptr
  import cpu_io_pkg::*;
#(
  parameter bit SP_WIDE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_lo_i,
  input  logic              we_hi_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [SP_W-1:0]   sp_o
);
  localparam int unsigned HI_LSB = SP_W - DATA_W;
  logic [SP_W-1:0] sp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp <= '0;
    end else begin
      if (we_lo_i)            sp[DATA_W-1:0]      <= wdata_i;
      if (we_hi_i && SP_WIDE) sp[HI_LSB +: DATA_W] <= wdata_i;
    end
  end

  assign sp_o = sp;

  a_r5_lo_keeps_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_lo_i |=> (sp_o[HI_LSB +: DATA_W] == $past(sp_o[HI_LSB +: DATA_W])));
  a_r6_narrow_drops_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_hi_i && !we_lo_i && !SP_WIDE) |=> $stable(sp_o));
  a_r6_hi_keeps_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_hi_i && !we_lo_i) |=> (sp_o[DATA_W-1:0] == $past(sp_o[DATA_W-1:0])));
endmodule

// File: rtl/io_ext_bridge.sv
module io_ext_bridge
  import cpu_io_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned IO_BASE = 32'h20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_hit_i,
  input  logic              write_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ext_rvalid_i,
  output logic              ext_req_o,
  output logic              ext_we_o,
  output logic [ADDR_W-1:0] ext_addr_o,
  output logic [DATA_W-1:0] ext_wdata_o,
  output logic              rd_pend_o
);
  logic rd_pend;

  assign ext_req_o   = ext_hit_i;
  assign ext_we_o    = ext_hit_i && write_i;
  assign ext_addr_o  = ADDR_W'(IO_BASE) + ADDR_W'(port_i);
  assign ext_wdata_o = wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_pend <= 1'b0;
    else         rd_pend <= ext_hit_i && !write_i;
  end
  assign rd_pend_o = rd_pend;

  a_r9_ext_resp_on_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_req_o && !ext_we_o) |=> ext_rvalid_i);
endmodule

// File: rtl/cpu_io_window.sv
module cpu_io_window
  import cpu_io_pkg::*;
#(
  parameter logic [3:0]  PAGE_EN = 4'b1111,
  parameter bit          SP_WIDE = 1'b1,
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned IO_BASE = 32'h20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [5:0]        acc_port_i,
  input  logic [7:0]        acc_wdata_i,
  output logic              rd_valid_o,
  output logic [7:0]        rd_data_o,
  output logic              ext_req_o,
  output logic              ext_we_o,
  output logic [ADDR_W-1:0] ext_addr_o,
  output logic [7:0]        ext_wdata_o,
  input  logic              ext_rvalid_i,
  input  logic [7:0]        ext_rdata_i,
  output logic [23:0]       page_d_o,
  output logic [23:0]       page_x_o,
  output logic [23:0]       page_y_o,
  output logic [23:0]       page_z_o,
  output logic [23:0]       ext_ind_o,
  output logic [15:0]       sp_o,
  output logic [7:0]        status_o
);
  localparam logic [NUM_FIELD-1:0] FIELD_EN = {1'b1, PAGE_EN};

  logic     win_hit, ext_hit, rd_pend_ext;
  win_sel_e win_sel;
  logic     [NUM_FIELD-1:0] field_we;
  logic     [FIELD_W-1:0]   field_q [NUM_FIELD];
  logic     [DATA_W-1:0]    field_b [NUM_FIELD];
  logic     [SP_W-1:0]      sp;
  logic     [DATA_W-1:0]    status_q, rd_byte, rd_win_q;
  logic     rd_valid_q, wr_acc;

  io_port_decode u_dec (
    .valid_i  (acc_valid_i),
    .port_i   (acc_port_i),
    .win_hit_o(win_hit),
    .ext_hit_o(ext_hit),
    .win_sel_o(win_sel)
  );

  assign wr_acc = win_hit && acc_write_i;

  for (genvar g = 0; g < NUM_FIELD; g++) begin : g_field
    assign field_we[g] = wr_acc && (win_sel == win_sel_e'(g));
    io_byte_field #(.ENABLE(FIELD_EN[g])) u_fld (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (field_we[g]),
      .wdata_i(acc_wdata_i),
      .q_o    (field_q[g]),
      .byte_o (field_b[g])
    );
  end

  io_stack_ptr #(.SP_WIDE(SP_WIDE)) u_sp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_lo_i(wr_acc && win_sel == WIN_SP_LO),
    .we_hi_i(wr_acc && win_sel == WIN_SP_HI),
    .wdata_i(acc_wdata_i),
    .sp_o   (sp)
  );

  io_ext_bridge #(.ADDR_W(ADDR_W), .IO_BASE(IO_BASE)) u_ext (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ext_hit_i   (ext_hit),
    .write_i     (acc_write_i),
    .port_i      (acc_port_i),
    .wdata_i     (acc_wdata_i),
    .ext_rvalid_i(ext_rvalid_i),
    .ext_req_o   (ext_req_o),
    .ext_we_o    (ext_we_o),
    .ext_addr_o  (ext_addr_o),
    .ext_wdata_o (ext_wdata_o),
    .rd_pend_o   (rd_pend_ext)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   status_q <= '0;
    else if (wr_acc && win_sel == WIN_STATUS)      status_q <= acc_wdata_i;
  end

  always_comb begin
    unique case (win_sel)
      WIN_SP_LO:  rd_byte = sp[DATA_W-1:0];
      WIN_SP_HI:  rd_byte = sp[SP_W-1 -: DATA_W];
      WIN_STATUS: rd_byte = status_q;
      default:    rd_byte = field_b[win_sel];
    endcase
  end

  // Window read data is captured at the request edge; external data passes through.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      rd_win_q   <= '0;
    end else begin
      rd_valid_q <= acc_valid_i && !acc_write_i;
      if (win_hit && !acc_write_i) rd_win_q <= rd_byte;
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_pend_ext ? ext_rdata_i : rd_win_q;

  assign page_d_o  = field_q[WIN_PAGE_D];
  assign page_x_o  = field_q[WIN_PAGE_X];
  assign page_y_o  = field_q[WIN_PAGE_Y];
  assign page_z_o  = field_q[WIN_PAGE_Z];
  assign ext_ind_o = field_q[WIN_EXT_IND];
  assign sp_o      = sp;
  assign status_o  = status_q;

  a_r9_read_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !acc_write_i) |=> rd_valid_o);
  a_r9_no_ext_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_port_i >= 6'h38) |-> !ext_req_o);
  a_r7_status_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_write_i && acc_port_i == 6'h3F) |=> (status_o == $past(acc_wdata_i)));
  a_r10_read_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !acc_write_i) |=> ($stable(sp_o) && $stable(status_o) && $stable(ext_ind_o)));
  a_r1_idle_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> !rd_valid_o);
endmodule

// File: tb/cpu_io_window_test.sv
module cpu_io_window_test;
  localparam logic [3:0] PEN = 4'b0101;
  localparam int unsigned BASE = 32'h20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic v = 0, w = 0, rv_in = 0;
  logic [5:0] p = 0;
  logic [7:0] d = 0, rd_in = 0;

  logic rv, rq, we, rq2, we2, rv2;
  logic [15:0] ad, ad2, sp, sp2;
  logic [7:0] rdat, wd, st, rdat2, wd2, st2;
  logic [23:0] pd, px, py, pz, ei, pd2, px2, py2, pz2, ei2;

  int n_vec = 0, n_bad = 0;

  always #4 clk = ~clk;

  cpu_io_window #(.PAGE_EN(PEN), .SP_WIDE(1'b1), .ADDR_W(16), .IO_BASE(BASE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(v), .acc_write_i(w), .acc_port_i(p),
    .acc_wdata_i(d), .rd_valid_o(rv), .rd_data_o(rdat), .ext_req_o(rq), .ext_we_o(we),
    .ext_addr_o(ad), .ext_wdata_o(wd), .ext_rvalid_i(rv_in), .ext_rdata_i(rd_in),
    .page_d_o(pd), .page_x_o(px), .page_y_o(py), .page_z_o(pz), .ext_ind_o(ei),
    .sp_o(sp), .status_o(st));

  cpu_io_window #(.PAGE_EN(PEN), .SP_WIDE(1'b0), .ADDR_W(16), .IO_BASE(BASE)) uut_sp8 (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(v), .acc_write_i(w), .acc_port_i(p),
    .acc_wdata_i(d), .rd_valid_o(rv2), .rd_data_o(rdat2), .ext_req_o(rq2), .ext_we_o(we2),
    .ext_addr_o(ad2), .ext_wdata_o(wd2), .ext_rvalid_i(rv_in), .ext_rdata_i(rd_in),
    .page_d_o(pd2), .page_x_o(px2), .page_y_o(py2), .page_z_o(pz2), .ext_ind_o(ei2),
    .sp_o(sp2), .status_o(st2));

  // reference model state
  logic [7:0]  m_fld [5];
  logic [15:0] m_sp, m_sp8;
  logic [7:0]  m_st;
  logic        e_rv, e_ext, pend;
  logic [7:0]  e_rd;
  logic [15:0] pend_addr;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] resp(logic [15:0] a);
    return a[7:0] ^ 8'hA5;
  endfunction

  task automatic check_state();
    chk("R3 page D (R2)", 32'(pd), 32'({m_fld[0], 16'h0}));
    chk("R3 page X", 32'(px), 32'({m_fld[1], 16'h0}));
    chk("R3 page Y", 32'(py), 32'({m_fld[2], 16'h0}));
    chk("R3 page Z", 32'(pz), 32'({m_fld[3], 16'h0}));
    chk("R4 ext indirect", 32'(ei), 32'({m_fld[4], 16'h0}));
    chk("R5 stack pointer", 32'(sp), 32'(m_sp));
    chk("R6 narrow stack pointer", 32'(sp2), 32'(m_sp8));
    chk("R7 status", 32'(st), 32'(m_st));
    chk("R9 read valid", 32'(rv), 32'(e_rv));
    if (e_rv) chk("R2 R9 R10 read data", 32'(rdat), 32'(e_ext ? resp(pend_addr) : e_rd));
  endtask

  task automatic op(logic vv, logic ww, logic [5:0] pp, logic [7:0] dd);
    int idx;
    @(negedge clk);
    rv_in = pend;
    rd_in = pend ? resp(pend_addr) : 8'h00;
    #1;
    check_state();
    v = vv; w = ww; p = pp; d = dd;
    #1;
    chk("R8 R9 ext request", 32'(rq), 32'(vv && pp < 6'h38));
    if (vv && pp < 6'h38) begin
      chk("R8 ext write enable", 32'(we), 32'(ww));
      chk("R8 ext address", 32'(ad), BASE + 32'(pp));
      if (ww) chk("R8 ext write data", 32'(wd), 32'(dd));
    end
    // model next state
    e_rv = vv && !ww;
    e_ext = 1'b0;
    pend = 1'b0;
    if (vv && pp < 6'h38) begin
      if (!ww) begin e_ext = 1'b1; pend = 1'b1; pend_addr = 16'(BASE) + 16'(pp); end
    end else if (vv) begin
      idx = int'(pp[2:0]);
      if (!ww) begin
        case (idx)
          5: e_rd = m_sp[7:0];
          6: e_rd = m_sp[15:8];
          7: e_rd = m_st;
          default: e_rd = m_fld[idx];
        endcase
      end else begin
        case (idx)
          4: m_fld[4] = dd;
          5: begin m_sp[7:0] = dd; m_sp8[7:0] = dd; end
          6: m_sp[15:8] = dd;
          7: m_st = dd;
          default: if (PEN[idx]) m_fld[idx] = dd;
        endcase
      end
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    for (int i = 0; i < 5; i++) m_fld[i] = 8'h00;
    m_sp = 0; m_sp8 = 0; m_st = 0; e_rv = 0; e_ext = 0; pend = 0; e_rd = 0; pend_addr = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset sp", 32'(sp), 0);
    chk("R1 reset status", 32'(st), 0);
    chk("R1 reset page D", 32'(pd), 0);
    chk("R1 reset read valid", 32'(rv), 0);
    chk("R1 reset ext request", 32'(rq), 0);
    rst_n = 1'b1;
    op(0, 0, 0, 0);
    // write every window port
    for (int k = 0; k < 8; k++) op(1, 1, 6'(8'h38 + k), 8'(8'h11 * (k + 1)));
    // read every window port
    for (int k = 0; k < 8; k++) op(1, 0, 6'(8'h38 + k), 0);
    // R5/R6 byte order: low after high and high after low
    op(1, 1, 6'h3E, 8'hC3); op(1, 1, 6'h3D, 8'h5A); op(1, 0, 6'h3E, 0); op(1, 0, 6'h3D, 0);
    // R10 read right after write, R3 absent page
    op(1, 1, 6'h39, 8'hEE); op(1, 0, 6'h39, 0);
    op(1, 1, 6'h3A, 8'h77); op(1, 0, 6'h3A, 0);
    // R8/R9 external accesses, interleaved with window traffic
    op(1, 1, 6'h00, 8'h42); op(1, 0, 6'h37, 0); op(1, 1, 6'h3F, 8'h81);
    op(1, 0, 6'h12, 0); op(1, 0, 6'h3F, 0); op(1, 0, 6'h05, 0); op(1, 0, 6'h06, 0);
    op(1, 1, 6'h3C, 8'h9D); op(1, 0, 6'h3C, 0); op(0, 0, 0, 0);
    // mixed traffic
    for (int k = 0; k < 600; k++) begin
      int r = $urandom;
      logic [5:0] pp = (r % 3 == 0) ? 6'($urandom % 64) : 6'(8'h38 + ($urandom % 8));
      op(1'($urandom % 5 != 0), 1'($urandom % 2), pp, 8'($urandom));
    end
    op(0, 0, 0, 0);
    op(0, 0, 0, 0);
    report();
  end
endmodule